// File: doc/BRIEF.md
# Set/Clear Control Register Bank

A 32-bit register bank behind a synchronous host port that writes in one cycle and reads with no wait. It decodes a 2 KB byte-address window. Bits [1:0] of the address are ignored, so every register is one aligned word. The bank holds four kinds of register:

- a read-only identification word;
- plain read/write words;
- a host control register reached through two addresses;
- an interrupt event register, also reached through two addresses, with its own mask word.

On a two-address register, a write to the lower address turns on the bits written as 1. A write to the address 4 bytes above turns those bits off. Bits written as 0 are left alone. Software can therefore change single bits without a read-modify-write sequence.

Hardware sets event bits through a pulse input. When the event register is read through its clear address, the read returns only the events that are enabled by the mask. The interrupt line is the OR of those enabled events. The host control value is driven out to the rest of the chip.

Top module: `scr_bank`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), the host control, event, mask, retry and bus-option registers read as zero, and `irq` and `hc_ctrl_o` are zero.
- R2: A write to byte offset 50h sets each host control bit whose data bit is 1 and leaves the other bits unchanged.
- R3: A write to byte offset 54h clears each host control bit whose data bit is 1 and leaves the other bits unchanged.
- R4: A read of 50h or of 54h returns the host control contents, and `hc_ctrl_o` carries the same value.
- R5: A read of 80h returns the raw event bits. A read of 84h returns the event bits ANDed with the mask word at 88h. A write to 80h sets event bits and a write to 84h clears them, in the same way as R2 and R3.
- R6: Each 1 on `hw_evt` at a clock edge sets the matching event bit. If the same bit is cleared by a write to 84h at the same edge, the bit ends up set.
- R7: `irq` is 1 exactly when the event bits ANDed with the mask are non-zero.
- R8: Offset 00h always reads the `VERSION_VAL` parameter, and writes to it have no effect.
- R9: Offsets 08h (retry limits), 20h (bus options) and 88h (interrupt mask) are plain read/write words.
- R10: Reads of reserved offsets (2Ch, 30h, 58h, 5Ch) and of any other unmapped offset return zero, and writes to them change no register.
- R11: Address bits [1:0] are ignored, so a byte address such as 53h selects the word at 50h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe; the write takes effect at this clock edge |
| addr | input | 11 | Byte address within the 2 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| hw_evt | input | 32 | Hardware event pulses; each 1 sets an event bit |
| hc_ctrl_o | output | 32 | Current host control register value |
| irq | output | 1 | Interrupt: any enabled event is pending |

## Verification
The set and clear addresses are driven with data patterns that overlap partly, fully and not at all with the bits already held. This separates a true bit-wise set or clear from a plain overwrite or a whole-word clear. An all-zero write to each address shows that zeros truly have no effect.

Event bits are raised both by hardware pulses and by software sets, under a mask that covers only some of them. Comparing the raw read, the masked read and `irq` then shows whether the mask is applied on the correct address only.

A hardware pulse and a software clear land on the same bit in the same cycle, to show that the set wins. A nearby bit is cleared alone at the same time, to show that the clear still works. Writes to reserved and unmapped offsets are followed by a read-back of every register, so any stray write shows up.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int REG_W   = 32;
  localparam int WIN_AW  = 11;            // 2 KB byte window
  localparam int WORD_AW = WIN_AW - 2;

  // word indices (byte offset / 4)
  localparam logic [WORD_AW-1:0] W_VER    = 9'h000; // 00h
  localparam logic [WORD_AW-1:0] W_RETRY  = 9'h002; // 08h
  localparam logic [WORD_AW-1:0] W_BUSOPT = 9'h008; // 20h
  localparam logic [WORD_AW-1:0] W_HC_SET = 9'h014; // 50h
  localparam logic [WORD_AW-1:0] W_HC_CLR = 9'h015; // 54h
  localparam logic [WORD_AW-1:0] W_EV_SET = 9'h020; // 80h
  localparam logic [WORD_AW-1:0] W_EV_CLR = 9'h021; // 84h
  localparam logic [WORD_AW-1:0] W_MASK   = 9'h022; // 88h

  typedef enum logic [3:0] {
    SEL_NONE, SEL_VER, SEL_RETRY, SEL_BUSOPT,
    SEL_HC_SET, SEL_HC_CLR, SEL_EV_SET, SEL_EV_CLR, SEL_MASK
  } sel_e;

  function automatic sel_e decode_word(input logic [WORD_AW-1:0] w);
    case (w)
      W_VER:    return SEL_VER;
      W_RETRY:  return SEL_RETRY;
      W_BUSOPT: return SEL_BUSOPT;
      W_HC_SET: return SEL_HC_SET;
      W_HC_CLR: return SEL_HC_CLR;
      W_EV_SET: return SEL_EV_SET;
      W_EV_CLR: return SEL_EV_CLR;
      W_MASK:   return SEL_MASK;
      default:  return SEL_NONE;
    endcase
  endfunction

  // next value of a set/clear register; hardware set has the last word
  function automatic logic [REG_W-1:0] sc_next(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] set_bits,
    input logic [REG_W-1:0] clr_bits,
    input logic [REG_W-1:0] hw_bits);
    return (cur & ~clr_bits) | set_bits | hw_bits;
  endfunction

  function automatic logic [REG_W-1:0] masked_view(
    input logic [REG_W-1:0] ev,
    input logic [REG_W-1:0] mask);
    return ev & mask;
  endfunction
endpackage

// File: rtl/scr_decode.sv
module scr_decode
  import scr_pkg::*;
(
  input  logic [WORD_AW-1:0] word_addr,
  output sel_e               sel,
  output logic               hit
);
  always_comb begin
    sel = decode_word(word_addr);
    hit = (sel != SEL_NONE);
  end
endmodule

// File: rtl/scr_sc_reg.sv
module scr_sc_reg
  import scr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] hw_set,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] set_bits, clr_bits;

  always_comb begin
    set_bits = set_we ? wdata : '0;
    clr_bits = clr_we ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= sc_next(q, set_bits, clr_bits, hw_set);
  end
endmodule

// File: rtl/scr_rw_reg.sv
module scr_rw_reg
  import scr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/scr_bank.sv
module scr_bank
  import scr_pkg::*;
#(
  parameter logic [31:0] VERSION_VAL = 32'h0001_0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WIN_AW-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [REG_W-1:0]  hw_evt,
  output logic [REG_W-1:0]  hc_ctrl_o,
  output logic              irq
);
  localparam int NUM_RW = 3;   // 0: retry, 1: bus options, 2: mask
  localparam int RW_RETRY = 0;
  localparam int RW_BUSOPT = 1;
  localparam int RW_MASK = 2;

  sel_e sel;
  logic dec_hit;
  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  scr_decode u_dec (.word_addr(addr[WIN_AW-1:2]), .sel(sel), .hit(dec_hit));

  // named write events
  logic wr_hc_set, wr_hc_clr, wr_ev_set, wr_ev_clr;
  logic [NUM_RW-1:0] rw_we;
  always_comb begin
    wr_hc_set = wr_en && (sel == SEL_HC_SET);
    wr_hc_clr = wr_en && (sel == SEL_HC_CLR);
    wr_ev_set = wr_en && (sel == SEL_EV_SET);
    wr_ev_clr = wr_en && (sel == SEL_EV_CLR);
    rw_we[RW_RETRY]  = wr_en && (sel == SEL_RETRY);
    rw_we[RW_BUSOPT] = wr_en && (sel == SEL_BUSOPT);
    rw_we[RW_MASK]   = wr_en && (sel == SEL_MASK);
  end

  logic [REG_W-1:0] hc_q, ev_q, mask_q, ev_masked;
  logic [REG_W-1:0] rw_q [NUM_RW];

  scr_sc_reg u_hc (
    .clk(clk), .rst(rst), .set_we(wr_hc_set), .clr_we(wr_hc_clr),
    .wdata(wdata), .hw_set({REG_W{1'b0}}), .q(hc_q));

  scr_sc_reg u_ev (
    .clk(clk), .rst(rst), .set_we(wr_ev_set), .clr_we(wr_ev_clr),
    .wdata(wdata), .hw_set(hw_evt), .q(ev_q));

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    scr_rw_reg u_rw (
      .clk(clk), .rst(rst), .we(rw_we[g]), .wdata(wdata), .q(rw_q[g]));
  end

  assign mask_q    = rw_q[RW_MASK];
  assign ev_masked = masked_view(ev_q, mask_q);
  assign irq       = |ev_masked;
  assign hc_ctrl_o = hc_q;

  always_comb begin
    case (sel)
      SEL_VER:                rdata = VERSION_VAL;
      SEL_RETRY:              rdata = rw_q[RW_RETRY];
      SEL_BUSOPT:             rdata = rw_q[RW_BUSOPT];
      SEL_MASK:               rdata = mask_q;
      SEL_HC_SET, SEL_HC_CLR: rdata = hc_q;
      SEL_EV_SET:             rdata = ev_q;
      SEL_EV_CLR:             rdata = ev_masked;
      default:                rdata = '0;
    endcase
  end
endmodule

// File: rtl/scr_bank_chk.sv
module scr_bank_chk
  import scr_pkg::*;
#(
  parameter logic [31:0] VERSION_VAL = 32'h0001_0010
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [WIN_AW-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic [REG_W-1:0]  rdata,
  input logic [REG_W-1:0]  hw_evt,
  input logic [REG_W-1:0]  hc_ctrl_o,
  input logic              irq,
  input logic [REG_W-1:0]  ev_q,
  input logic              dec_hit
);
  logic [WORD_AW-1:0] wa;
  assign wa = addr[WIN_AW-1:2];

  assert_set_raises_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wa == W_HC_SET) |=> hc_ctrl_o == ($past(hc_ctrl_o) | $past(wdata)));

  assert_clr_lowers_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wa == W_HC_CLR) |=> hc_ctrl_o == ($past(hc_ctrl_o) & ~$past(wdata)));

  assert_readback_R4: assert property (@(posedge clk) disable iff (rst)
    (wa == W_HC_SET || wa == W_HC_CLR) |-> rdata == hc_ctrl_o);

  assert_hw_wins_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ev_q & $past(hw_evt)) == $past(hw_evt));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (wa == W_EV_CLR && rdata != '0) |-> irq);

  assert_version_R8: assert property (@(posedge clk) disable iff (rst)
    (wa == W_VER) |-> rdata == VERSION_VAL);

  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !dec_hit) |=> $stable(hc_ctrl_o));

  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
    !dec_hit |-> rdata == '0);
endmodule

bind scr_bank scr_bank_chk #(.VERSION_VAL(VERSION_VAL)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .hw_evt(hw_evt), .hc_ctrl_o(hc_ctrl_o), .irq(irq),
  .ev_q(ev_q), .dec_hit(dec_hit));

// File: tb/sim_scr_bank.sv
`timescale 1ns/1ps
module sim_scr_bank;
  localparam logic [31:0] VER = 32'h0001_0010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [10:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] hw_evt = '0;
  logic [31:0] rdata, hc_ctrl_o;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  scr_bank #(.VERSION_VAL(VER)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hw_evt(hw_evt), .hc_ctrl_o(hc_ctrl_o), .irq(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // one write cycle, optionally with a hardware event pulse in the same cycle
  task automatic wr(input logic [10:0] a, input logic [31:0] d, input logic [31:0] ev);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; hw_evt = ev;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; hw_evt = '0;
  endtask

  task automatic pulse_evt(input logic [31:0] ev);
    @(negedge clk);
    hw_evt = ev;
    @(negedge clk);
    hw_evt = '0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(11'h000, d); check("R8 version after reset", d, VER);
    rd(11'h050, d); check("R1 hc set addr", d, '0);
    rd(11'h054, d); check("R1 hc clr addr", d, '0);
    rd(11'h008, d); check("R1 retry", d, '0);
    rd(11'h020, d); check("R1 busopt", d, '0);
    rd(11'h080, d); check("R1 event", d, '0);
    rd(11'h088, d); check("R1 mask", d, '0);
    check("R1 irq", {31'b0, irq}, '0);
    check("R1 hc_ctrl_o", hc_ctrl_o, '0);
  endtask

  task automatic t_set_clear;
    logic [31:0] d;
    wr(11'h050, 32'hA5A5_0F0F, '0);
    rd(11'h050, d); check("R2 first set", d, 32'hA5A5_0F0F);
    wr(11'h050, 32'h0000_F00F, '0);
    rd(11'h050, d); check("R2 partial overlap set", d, 32'hA5A5_FF0F);
    wr(11'h050, 32'h0, '0);
    rd(11'h050, d); check("R2 zero set no effect", d, 32'hA5A5_FF0F);
    wr(11'h054, 32'h0000_0F0F, '0);
    rd(11'h054, d); check("R3 clear via clr addr, R4 read clr", d, 32'hA5A5_F000);
    wr(11'h054, 32'h0, '0);
    rd(11'h050, d); check("R3 zero clear no effect", d, 32'hA5A5_F000);
    check("R4 hc_ctrl_o matches", hc_ctrl_o, 32'hA5A5_F000);
    wr(11'h057, 32'hA000_0000, '0);   // byte address inside 54h word
    rd(11'h052, d); check("R11 low address bits ignored", d, 32'h05A5_F000);
  endtask

  task automatic t_rw;
    logic [31:0] d;
    wr(11'h008, 32'h1234_5678, '0);
    wr(11'h020, 32'hCAFE_0001, '0);
    rd(11'h008, d); check("R9 retry word", d, 32'h1234_5678);
    rd(11'h020, d); check("R9 busopt word", d, 32'hCAFE_0001);
    wr(11'h008, 32'h0000_0003, '0);
    rd(11'h008, d); check("R9 retry overwrite", d, 32'h0000_0003);
    wr(11'h000, 32'hFFFF_FFFF, '0);
    rd(11'h000, d); check("R8 version write ignored", d, VER);
  endtask

  task automatic t_events;
    logic [31:0] d;
    wr(11'h088, 32'h0000_00F0, '0);
    rd(11'h088, d); check("R9 mask word", d, 32'h0000_00F0);
    check("R7 irq low with no events", {31'b0, irq}, '0);
    pulse_evt(32'h0000_0011);
    rd(11'h080, d); check("R6 hw pulse raw", d, 32'h0000_0011);
    rd(11'h084, d); check("R5 masked view", d, 32'h0000_0010);
    check("R7 irq high", {31'b0, irq}, 32'h1);
    wr(11'h080, 32'h0000_0100, '0);
    rd(11'h080, d); check("R5 sw set event", d, 32'h0000_0111);
    wr(11'h084, 32'h0000_0010, '0);
    rd(11'h080, d); check("R5 sw clear event raw", d, 32'h0000_0101);
    rd(11'h084, d); check("R5 masked empty", d, 32'h0);
    check("R7 irq low, unmasked bits pending", {31'b0, irq}, '0);
    wr(11'h084, 32'h0000_0101, 32'h0000_0001);
    rd(11'h080, d); check("R6 set wins over clear", d, 32'h0000_0001);
    wr(11'h084, 32'h0000_0001, 32'h0000_0020);
    rd(11'h080, d); check("R6 clear with other hw bit", d, 32'h0000_0020);
    check("R7 irq on masked hw bit", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    logic [10:0] bad [6] = '{11'h02C, 11'h030, 11'h058, 11'h05C, 11'h400, 11'h7FC};
    for (int i = 0; i < 6; i++) wr(bad[i], 32'hFFFF_FFFF, '0);
    for (int i = 0; i < 6; i++) begin
      rd(bad[i], d); check("R10 unmapped read zero", d, '0);
    end
    rd(11'h050, d); check("R10 hc untouched", d, 32'h05A5_F000);
    rd(11'h008, d); check("R10 retry untouched", d, 32'h0000_0003);
    rd(11'h020, d); check("R10 busopt untouched", d, 32'hCAFE_0001);
    rd(11'h080, d); check("R10 event untouched", d, 32'h0000_0020);
    rd(11'h088, d); check("R10 mask untouched", d, 32'h0000_00F0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_clear();
    t_rw();
    t_events();
    t_reserved();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule